// File: doc/BRIEF.md
# Coprime ring-counter clock-enable divider

This block turns a fast system clock into a slow, single-cycle clock-enable strobe without any wide counter compared against a terminal count. The division ratio is split into a power-of-two part and a set of distinct small primes.

The power-of-two part comes from a binary prescaler. The prescaler's carry-out is the advance signal for the next stage. Each prime becomes a circulating one-hot shift ring of that length. The strobe fires when every ring reaches its tap position on the same advance, so the period is 2^PRE_W times the product of the ring lengths.

A typical use is deriving a slow event rate, such as a few hertz, from a clock of tens of megahertz. Downstream registers use the strobe as their enable and keep running on the system clock. A global enable freezes the whole divider, and a synchronous reset restarts it.

Top module: `ring_strobe_divider`

## Requirements
- R1: Every ring length lies between 2 and 32 and the lengths are pairwise coprime; any other parameter set is rejected when the design is elaborated.
- R2: In the cycle after a synchronous reset, the prescaler is zero, every ring holds a single 1 at bit 0, `strobe` is low and every bit of `taps` is low.
- R3: The rings advance once every 2^PRE_W enabled cycles, on the prescaler carry-out. With PRE_W = 0 they advance on every enabled cycle.
- R4: Each ring always holds exactly one set bit. On an advance, the bit moves one place toward the higher index, and bit L-1 wraps to bit 0.
- R5: `taps[i]` is high exactly while ring i holds its bit at position L-1. With e enabled cycles since reset, this is when floor(e / 2^PRE_W) mod L = L-1.
- R6: `strobe` is high for exactly one cycle per period. Successive strobes are P = 2^PRE_W * product of the ring lengths enabled cycles apart.
- R7: `strobe` is registered. With `en` held high from reset, the first strobe is visible P cycles after reset is released.
- R8: While `en` is low, the prescaler and the rings hold their state, and `strobe` is low in the following cycle.
- R9: `strobe` is high only when every ring has just returned to bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Global enable; low freezes the divider |
| strobe | output | 1 | Registered one-cycle enable pulse, once per period |
| taps | output | N_RINGS | Per-ring tap bit (ring bit L-1) |

## Verification
Two configurations are checked cycle by cycle against an arithmetic model built on the count of enabled cycles. The first has a 2-bit prescaler and rings of 3, 5 and 7. The second has no prescaler and rings of 2, 3 and 5. The enable is first held high for several full periods, which fixes the first-strobe position and the spacing between strobes. It is then toggled in an irregular pattern, which separates a divider that freezes correctly from one that counts raw clock cycles. A reset in the middle of a period shows that ring and prescaler state are fully restarted rather than carried over.

// File: rtl/ring_div_pkg.sv
package ring_div_pkg;

    localparam int unsigned RING_LEN_LIMIT = 32;
    localparam int unsigned RING_LEN_FLOOR = 2;

    // Greatest common divisor, used for the coprime check at elaboration.
    function automatic int unsigned gcd(input int unsigned a, input int unsigned b);
        int unsigned x;
        int unsigned y;
        int unsigned t;
        x = a;
        y = b;
        for (int k = 0; k < 64; k++) begin
            if (y != 0) begin
                t = x % y;
                x = y;
                y = t;
            end
        end
        return x;
    endfunction

endpackage

// File: rtl/rdiv_prescaler.sv
module rdiv_prescaler #(
    parameter int unsigned W = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic adv
);

    if (W == 0) begin : g_bypass
        // No power-of-two stage: the rings step on every enabled cycle.
        assign adv = en;
    end else begin : g_count
        typedef struct packed {
            logic [W-1:0] cnt;
        } pre_state_t;

        pre_state_t st_d, st_q;
        logic [W:0] sum;

        always_comb begin
            st_d = st_q;
            // The carry-out of the increment is the advance; no compare against a terminal value.
            sum  = {1'b0, st_q.cnt} + {{W{1'b0}}, 1'b1};
            if (en) begin
                st_d.cnt = sum[W-1:0];
            end
            adv = en & sum[W];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end
    end

endmodule

// File: rtl/rdiv_ring.sv
module rdiv_ring #(
    parameter int unsigned L = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [L-1:0] state,
    output logic         tap
);

    typedef struct packed {
        logic [L-1:0] bits;
    } ring_state_t;

    ring_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.bits = {st_q.bits[L-2:0], st_q.bits[L-1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.bits <= {{(L-1){1'b0}}, 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign state = st_q.bits;
    assign tap   = st_q.bits[L-1];

endmodule

// File: rtl/rdiv_strobe_reg.sv
module rdiv_strobe_reg #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic [N-1:0] taps,
    output logic         strobe
);

    typedef struct packed {
        logic pulse;
    } strobe_state_t;

    strobe_state_t st_d, st_q;

    always_comb begin
        // All rings at their last bit on an advance: they land on bit 0 together.
        st_d.pulse = adv & (&taps);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe = st_q.pulse;

endmodule

// File: rtl/ring_strobe_divider.sv
module ring_strobe_divider #(
    parameter int unsigned PRE_W              = 2,
    parameter int unsigned N_RINGS            = 3,
    parameter int unsigned RING_LEN [N_RINGS] = '{3, 5, 7}
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    output logic               strobe,
    output logic [N_RINGS-1:0] taps
);

    function automatic int unsigned f_max_len();
        int unsigned m;
        m = 0;
        for (int k = 0; k < N_RINGS; k++) begin
            if (RING_LEN[k] > m) m = RING_LEN[k];
        end
        return m;
    endfunction

    localparam int unsigned MAX_L = f_max_len();

    logic                           adv;
    logic [N_RINGS-1:0][MAX_L-1:0]  ring_vec;

    rdiv_prescaler #(.W(PRE_W)) u_pre (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .adv (adv)
    );

    for (genvar i = 0; i < N_RINGS; i++) begin : g_ring
        localparam int unsigned L = RING_LEN[i];
        logic [L-1:0] st;

        rdiv_ring #(.L(L)) u_ring (
            .clk   (clk),
            .rst   (rst),
            .adv   (adv),
            .state (st),
            .tap   (taps[i])
        );

        assign ring_vec[i] = MAX_L'(st);
    end

    rdiv_strobe_reg #(.N(N_RINGS)) u_out (
        .clk    (clk),
        .rst    (rst),
        .adv    (adv),
        .taps   (taps),
        .strobe (strobe)
    );

endmodule

// File: rtl/rdiv_checker.sv
module rdiv_checker #(
    parameter int unsigned N                = 3,
    parameter int unsigned MAX_L            = 7,
    parameter int unsigned RING_LEN [N]     = '{3, 5, 7}
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   en,
    input logic                   adv,
    input logic                   strobe,
    input logic [N-1:0][MAX_L-1:0] ring_vec
);

    function automatic bit f_lens_ok();
        bit ok;
        ok = 1'b1;
        for (int a = 0; a < N; a++) begin
            if (RING_LEN[a] < ring_div_pkg::RING_LEN_FLOOR) ok = 1'b0;
            if (RING_LEN[a] > ring_div_pkg::RING_LEN_LIMIT) ok = 1'b0;
            for (int b = a + 1; b < N; b++) begin
                if (ring_div_pkg::gcd(RING_LEN[a], RING_LEN[b]) != 1) ok = 1'b0;
            end
        end
        return ok;
    endfunction

    localparam bit LENS_OK = f_lens_ok();

    // R1: parameter set rejected at elaboration
    if (!LENS_OK) begin : g_r1_bad_lens
        $error("R1: ring lengths must be 2..32 and pairwise coprime");
    end

    // R8: a disabled cycle never advances and never produces a strobe next
    a_r8_no_adv_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |-> !adv);
    a_r8_no_strobe_after_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> !strobe);

    // R6: strobe lasts a single cycle (every period is at least 2)
    a_r6_single_cycle: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

    for (genvar i = 0; i < N; i++) begin : g_ring_chk
        // R4: one-hot at all times
        a_r4_onehot: assert property (@(posedge clk) disable iff (rst)
            $countones(ring_vec[i]) == 1);
        // R3: a ring moves when advanced and holds otherwise
        a_r3_moves_on_adv: assert property (@(posedge clk) disable iff (rst)
            adv |=> ring_vec[i] != $past(ring_vec[i]));
        a_r3_holds_idle: assert property (@(posedge clk) disable iff (rst)
            !adv |=> $stable(ring_vec[i]));
        // R9: strobe coincides with every ring at bit 0
        a_r9_aligned: assert property (@(posedge clk) disable iff (rst)
            strobe |-> ring_vec[i][0]);
    end

endmodule

bind ring_strobe_divider rdiv_checker #(
    .N        (N_RINGS),
    .MAX_L    (MAX_L),
    .RING_LEN (RING_LEN)
) u_rdiv_checker (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .adv      (adv),
    .strobe   (strobe),
    .ring_vec (ring_vec)
);

// File: tb/test_ring_strobe_divider.sv
module test_ring_strobe_divider;

    localparam int unsigned WA = 2;
    localparam int unsigned PA = 4 * 3 * 5 * 7;   // 420
    localparam int unsigned WB = 0;
    localparam int unsigned PB = 2 * 3 * 5;       // 30

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic       strobe_a, strobe_b;
    logic [2:0] taps_a, taps_b;

    int unsigned lens_a [3] = '{3, 5, 7};
    int unsigned lens_b [3] = '{2, 3, 5};

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    ring_strobe_divider #(.PRE_W(WA), .N_RINGS(3), .RING_LEN('{3, 5, 7})) i_ring_strobe_divider (
        .clk (clk), .rst (rst), .en (en), .strobe (strobe_a), .taps (taps_a)
    );

    ring_strobe_divider #(.PRE_W(WB), .N_RINGS(3), .RING_LEN('{2, 3, 5})) i_ring_strobe_divider_nopre (
        .clk (clk), .rst (rst), .en (en), .strobe (strobe_b), .taps (taps_b)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Model state: enabled cycles since reset, expected strobes, enabled cycles since last strobe
    longint e_cnt = 0;
    bit     exp_sa = 1'b0, exp_sb = 1'b0;
    int     gap_a = -1, gap_b = -1;
    bit     in_reset = 1'b1;

    function automatic bit tap_exp(input longint e, input int unsigned w, input int unsigned l);
        return ((e >> w) % l) == l - 1;
    endfunction

    task automatic check_cycle(input string phase);
        for (int i = 0; i < 3; i++) begin
            chk(taps_a[i] == tap_exp(e_cnt, WA, lens_a[i]), {"R5 R3 taps A ", phase},
                int'(taps_a[i]), int'(tap_exp(e_cnt, WA, lens_a[i])));
            chk(taps_b[i] == tap_exp(e_cnt, WB, lens_b[i]), {"R5 R3 taps B ", phase},
                int'(taps_b[i]), int'(tap_exp(e_cnt, WB, lens_b[i])));
        end
        chk(strobe_a == exp_sa, {"R6 R7 R8 strobe A ", phase}, int'(strobe_a), int'(exp_sa));
        chk(strobe_b == exp_sb, {"R6 R7 R8 strobe B ", phase}, int'(strobe_b), int'(exp_sb));
        if (strobe_a) begin
            if (gap_a >= 0) chk(gap_a == int'(PA), "R1 R6 interval A", gap_a, int'(PA));
            gap_a = 0;
        end
        if (strobe_b) begin
            if (gap_b >= 0) chk(gap_b == int'(PB), "R1 R6 interval B", gap_b, int'(PB));
            gap_b = 0;
        end
    endtask

    // Apply next inputs, then predict the state after the coming edge.
    task automatic step(input bit r, input bit e);
        rst = r;
        en  = e;
        if (r) begin
            e_cnt  = 0;
            exp_sa = 1'b0;
            exp_sb = 1'b0;
            gap_a  = -1;
            gap_b  = -1;
        end else begin
            exp_sa = e && ((e_cnt % PA) == PA - 1);
            exp_sb = e && ((e_cnt % PB) == PB - 1);
            if (e) begin
                e_cnt++;
                if (gap_a >= 0) gap_a++;
                if (gap_b >= 0) gap_b++;
            end
        end
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        // R2: reset state visible at the outputs
        chk(strobe_a == 1'b0 && taps_a == 3'b000, "R2 reset A", int'({strobe_a, taps_a}), 0);
        chk(strobe_b == 1'b0 && taps_b == 3'b000, "R2 reset B", int'({strobe_b, taps_b}), 0);
        gap_a = 0;
        gap_b = 0;
        // R7: free running from reset; first strobe after exactly P cycles
        for (int c = 0; c < 3 * int'(PA) + 7; c++) begin
            step(1'b0, 1'b1);
            check_cycle("run");
            if (c == int'(PA) - 1) chk(strobe_a == 1'b1, "R7 first strobe A", int'(strobe_a), 1);
            if (c == int'(PB) - 1) chk(strobe_b == 1'b1, "R7 first strobe B", int'(strobe_b), 1);
        end
        // R8: irregular enable pattern
        for (int c = 0; c < 1800; c++) begin
            step(1'b0, ((c % 3) != 0) && ((c % 11) != 5));
            check_cycle("gated");
        end
        // R2: reset in the middle of a period
        step(1'b1, 1'b1);
        check_cycle("midreset");
        chk(taps_a == 3'b000 && taps_b == 3'b000, "R2 midreset taps", int'({taps_a, taps_b}), 0);
        gap_a = 0;
        gap_b = 0;
        for (int c = 0; c < 2 * int'(PA) + 3; c++) begin
            step(1'b0, 1'b1);
            check_cycle("rerun");
            if (c == int'(PA) - 1) chk(strobe_a == 1'b1, "R7 strobe after reset A", int'(strobe_a), 1);
        end
        // R8: long disable holds every output
        for (int c = 0; c < 50; c++) begin
            step(1'b0, 1'b0);
            check_cycle("hold");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule